// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the control and status register bank of a multi-channel DMA layer. Software reaches it over a simple register bus with a 10-bit register number, a write strobe, a read strobe and 32-bit data paths. It holds one global configuration word, an error status word and an interrupt enable word. Transmit and receive channels each have an active-set word and an active-reset word, an end-of-buffer status word and a descriptor-error status word. Each transmit and receive channel has its own descriptor table pointer, and each receive channel has its own buffer size.

The descriptor fetch engine reports events on set-pulse inputs, one 32-bit vector per status word. A bit stays set until software writes a one to it. Each status word drives one interrupt line, gated by its own enable bit. Writing the configuration word with its top bit set performs a soft reset of the control and status state before the new configuration is stored. The channel counts are parameters, and each register window answers only for channels that exist.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset the configuration word reads 0x0007C000. Error status, interrupt enable, all four event status words, both active-set words, both active-reset words, all pointers and buffer sizes read zero. `rd_data` is zero and every interrupt line is low.
- R2: A read strobe sampled at a clock edge loads `rd_data` with the addressed register as it stood before that edge, including when a write to the same register happens in the same cycle. Without a read strobe, `rd_data` holds its value.
- R3: A write to register 0x180 stores the write data ANDed with 0x00FFC087.
- R4: A write to 0x180 with bit 31 set first clears error status, interrupt enable, both active-set words and the four event status words. It then stores the masked configuration. The active-reset words, pointers and buffer sizes keep their values.
- R5: Interrupt enable (0x182) keeps write bits 4:0. Transmit active set and reset (0x184, 0x185) keep bits 31:28. Receive active set and reset (0x190, 0x191) keep bits 31:30.
- R6: Error status (0x181), transmit end-of-buffer (0x186), transmit descriptor-error (0x187), receive end-of-buffer (0x192) and receive descriptor-error (0x193) are write-one-to-clear. Each written 1 clears that bit and each written 0 leaves it.
- R7: A set-pulse bit sets its status bit at the next edge, even when software clears or soft-resets that bit in the same cycle. Status bits never drop without a clear or a soft reset.
- R8: Each interrupt line is high while its status word is nonzero and its enable bit is 1. Enable bit 0 gates transmit end-of-buffer, bit 1 receive end-of-buffer, bit 2 transmit descriptor-error, bit 3 receive descriptor-error and bit 4 error status. A line follows the registered state one cycle after the event.
- R9: Transmit pointer i sits at 0x1A0+i for i below `TX_CH`, and receive pointer i sits at 0x1C0+i for i below `RX_CH`. Each stores all 32 bits.
- R10: Buffer size i sits at 0x1E0+i for i below `RX_CH` and keeps the low 8 bits of a write.
- R11: A register number outside the defined ones, including a window offset at or beyond the channel count, reads zero. A write to it changes no register.
- R12: `TX_CH` and `RX_CH` must each lie in 1..32. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_num | input | 10 | Register number of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| err_set | input | 32 | Set pulses for error status |
| tx_eob_set | input | 32 | Set pulses for transmit end-of-buffer status |
| rx_eob_set | input | 32 | Set pulses for receive end-of-buffer status |
| tx_derr_set | input | 32 | Set pulses for transmit descriptor-error status |
| rx_derr_set | input | 32 | Set pulses for receive descriptor-error status |
| irq_tx_eob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rx_eob | output | 1 | Receive end-of-buffer interrupt |
| irq_tx_derr | output | 1 | Transmit descriptor-error interrupt |
| irq_rx_derr | output | 1 | Receive descriptor-error interrupt |
| irq_err | output | 1 | Error status interrupt |

## Verification
The assertions check several rules on every cycle:
- a write-one clears its error bit unless a set pulse hits that bit in the same cycle;
- a set pulse always lands;
- error status bits never vanish without a clear or a soft reset;
- a soft reset empties error status;
- pointer storage never moves without a write inside its window;
- read data holds between strobes;
- turning all enables off silences every interrupt line.

Only the directed scenarios can show the exact stored values. These include the per-register write masks, the reset values, and which state survives a soft reset. They also include the read-before-write ordering on a shared cycle, the zero returned just past each window end, and the mapping of enable bits to interrupt lines.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    localparam int REG_NUM_W = 10;
    localparam int DATA_W    = 32;
    localparam int MAX_CH    = 32;
    localparam int IRQ_GROUPS = 5;

    // register numbers decoded by the control bus
    localparam logic [REG_NUM_W-1:0] CSR_GCFG      = 10'h180;
    localparam logic [REG_NUM_W-1:0] CSR_ERRSTAT   = 10'h181;
    localparam logic [REG_NUM_W-1:0] CSR_IRQEN     = 10'h182;
    localparam logic [REG_NUM_W-1:0] CSR_TXACT_SET = 10'h184;
    localparam logic [REG_NUM_W-1:0] CSR_TXACT_RST = 10'h185;
    localparam logic [REG_NUM_W-1:0] CSR_TXEOB     = 10'h186;
    localparam logic [REG_NUM_W-1:0] CSR_TXDERR    = 10'h187;
    localparam logic [REG_NUM_W-1:0] CSR_RXACT_SET = 10'h190;
    localparam logic [REG_NUM_W-1:0] CSR_RXACT_RST = 10'h191;
    localparam logic [REG_NUM_W-1:0] CSR_RXEOB     = 10'h192;
    localparam logic [REG_NUM_W-1:0] CSR_RXDERR    = 10'h193;
    localparam logic [REG_NUM_W-1:0] WIN_TXPTR     = 10'h1A0;
    localparam logic [REG_NUM_W-1:0] WIN_RXPTR     = 10'h1C0;
    localparam logic [REG_NUM_W-1:0] WIN_RXBSZ     = 10'h1E0;

    // write keep masks and reset value
    localparam logic [DATA_W-1:0] CFG_KEEP   = 32'h00FF_C087;
    localparam logic [DATA_W-1:0] CFG_RESET  = 32'h0007_C000;
    localparam logic [DATA_W-1:0] IEN_KEEP   = 32'h0000_001F;
    localparam logic [DATA_W-1:0] TXACT_KEEP = 32'hF000_0000;
    localparam logic [DATA_W-1:0] RXACT_KEEP = 32'hC000_0000;
    localparam logic [DATA_W-1:0] PTR_KEEP   = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] BSZ_KEEP   = 32'h0000_00FF;

    // interrupt group index = enable bit position
    localparam int IG_TX_EOB  = 0;
    localparam int IG_RX_EOB  = 1;
    localparam int IG_TX_DERR = 2;
    localparam int IG_RX_DERR = 3;
    localparam int IG_ERR     = 4;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] err;
        logic [DATA_W-1:0] irq_en;
        logic [DATA_W-1:0] tx_act_set;
        logic [DATA_W-1:0] tx_act_rst;
        logic [DATA_W-1:0] tx_eob;
        logic [DATA_W-1:0] tx_derr;
        logic [DATA_W-1:0] rx_act_set;
        logic [DATA_W-1:0] rx_act_rst;
        logic [DATA_W-1:0] rx_eob;
        logic [DATA_W-1:0] rx_derr;
    } csr_regs_t;

endpackage

// File: rtl/dma_csr_core.sv
module dma_csr_core
    import dma_csr_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [REG_NUM_W-1:0]                 reg_num_i,
    input  logic                                 wr_en_i,
    input  logic [DATA_W-1:0]                    wr_data_i,
    input  logic [DATA_W-1:0]                    err_set_i,
    input  logic [DATA_W-1:0]                    tx_eob_set_i,
    input  logic [DATA_W-1:0]                    rx_eob_set_i,
    input  logic [DATA_W-1:0]                    tx_derr_set_i,
    input  logic [DATA_W-1:0]                    rx_derr_set_i,
    output logic [DATA_W-1:0]                    rdata_o,
    output logic [IRQ_GROUPS-1:0][DATA_W-1:0]    stat_o,
    output logic [IRQ_GROUPS-1:0]                ien_o
);

    csr_regs_t r_d, r_q;
    logic      soft_rst;

    always_comb begin
        r_d      = r_q;
        soft_rst = wr_en_i && (reg_num_i == CSR_GCFG) && wr_data_i[DATA_W-1];

        if (soft_rst) begin
            r_d.err        = '0;
            r_d.irq_en     = '0;
            r_d.tx_act_set = '0;
            r_d.rx_act_set = '0;
            r_d.tx_eob     = '0;
            r_d.tx_derr    = '0;
            r_d.rx_eob     = '0;
            r_d.rx_derr    = '0;
        end

        if (wr_en_i) begin
            case (reg_num_i)
                CSR_GCFG:      r_d.cfg        = wr_data_i & CFG_KEEP;
                CSR_ERRSTAT:   r_d.err        = r_q.err & ~wr_data_i;
                CSR_IRQEN:     r_d.irq_en     = wr_data_i & IEN_KEEP;
                CSR_TXACT_SET: r_d.tx_act_set = wr_data_i & TXACT_KEEP;
                CSR_TXACT_RST: r_d.tx_act_rst = wr_data_i & TXACT_KEEP;
                CSR_TXEOB:     r_d.tx_eob     = r_q.tx_eob & ~wr_data_i;
                CSR_TXDERR:    r_d.tx_derr    = r_q.tx_derr & ~wr_data_i;
                CSR_RXACT_SET: r_d.rx_act_set = wr_data_i & RXACT_KEEP;
                CSR_RXACT_RST: r_d.rx_act_rst = wr_data_i & RXACT_KEEP;
                CSR_RXEOB:     r_d.rx_eob     = r_q.rx_eob & ~wr_data_i;
                CSR_RXDERR:    r_d.rx_derr    = r_q.rx_derr & ~wr_data_i;
                default: ;
            endcase
        end

        // hardware events win over a clear in the same cycle
        r_d.err     = r_d.err     | err_set_i;
        r_d.tx_eob  = r_d.tx_eob  | tx_eob_set_i;
        r_d.rx_eob  = r_d.rx_eob  | rx_eob_set_i;
        r_d.tx_derr = r_d.tx_derr | tx_derr_set_i;
        r_d.rx_derr = r_d.rx_derr | rx_derr_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.cfg <= CFG_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_num_i)
            CSR_GCFG:      rdata_o = r_q.cfg;
            CSR_ERRSTAT:   rdata_o = r_q.err;
            CSR_IRQEN:     rdata_o = r_q.irq_en;
            CSR_TXACT_SET: rdata_o = r_q.tx_act_set;
            CSR_TXACT_RST: rdata_o = r_q.tx_act_rst;
            CSR_TXEOB:     rdata_o = r_q.tx_eob;
            CSR_TXDERR:    rdata_o = r_q.tx_derr;
            CSR_RXACT_SET: rdata_o = r_q.rx_act_set;
            CSR_RXACT_RST: rdata_o = r_q.rx_act_rst;
            CSR_RXEOB:     rdata_o = r_q.rx_eob;
            CSR_RXDERR:    rdata_o = r_q.rx_derr;
            default:       rdata_o = '0;
        endcase
    end

    always_comb begin
        stat_o             = '0;
        stat_o[IG_TX_EOB]  = r_q.tx_eob;
        stat_o[IG_RX_EOB]  = r_q.rx_eob;
        stat_o[IG_TX_DERR] = r_q.tx_derr;
        stat_o[IG_RX_DERR] = r_q.rx_derr;
        stat_o[IG_ERR]     = r_q.err;
        ien_o              = r_q.irq_en[IRQ_GROUPS-1:0];
    end

    // assertions
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && wr_en_i && (reg_num_i == CSR_ERRSTAT)
        |=> ((r_q.err & $past(wr_data_i) & ~$past(err_set_i)) == '0));

    a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && (err_set_i != '0)
        |=> ((r_q.err & $past(err_set_i)) == $past(err_set_i)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !(wr_en_i && (reg_num_i == CSR_ERRSTAT || reg_num_i == CSR_GCFG))
        |=> (($past(r_q.err) & ~r_q.err) == '0));

    a_r4_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && wr_en_i && (reg_num_i == CSR_GCFG) && wr_data_i[DATA_W-1]
        && (err_set_i == '0)
        |=> (r_q.err == '0) && (r_q.irq_en == '0));

endmodule

// File: rtl/dma_win_bank.sv
module dma_win_bank
    import dma_csr_pkg::*;
#(
    parameter int                   N    = 4,
    parameter logic [REG_NUM_W-1:0] BASE = 10'h1A0,
    parameter logic [DATA_W-1:0]    KEEP = 32'hFFFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_NUM_W-1:0] reg_num_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    output logic [DATA_W-1:0]    rdata_o
);

    logic [N-1:0][DATA_W-1:0] ent_d, ent_q;
    logic [REG_NUM_W-1:0]     off;
    logic                     hit;

    assign off = reg_num_i - BASE;
    assign hit = (reg_num_i >= BASE) && (off < REG_NUM_W'(N));

    always_comb begin
        ent_d   = ent_q;
        rdata_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit && (off == REG_NUM_W'(i))) begin
                rdata_o = ent_q[i];
                if (wr_en_i) ent_d[i] = wr_data_i & KEEP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r11_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !(wr_en_i && hit) |=> (ent_q == $past(ent_q)));

endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
    import dma_csr_pkg::*;
#(
    parameter int GROUPS = IRQ_GROUPS
) (
    input  logic [GROUPS-1:0][DATA_W-1:0] stat_i,
    input  logic [GROUPS-1:0]             en_i,
    output logic [GROUPS-1:0]             irq_o
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign irq_o[g] = en_i[g] && (stat_i[g] != '0);
    end

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  reg_num,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic [31:0] err_set,
    input  logic [31:0] tx_eob_set,
    input  logic [31:0] rx_eob_set,
    input  logic [31:0] tx_derr_set,
    input  logic [31:0] rx_derr_set,
    output logic        irq_tx_eob,
    output logic        irq_rx_eob,
    output logic        irq_tx_derr,
    output logic        irq_rx_derr,
    output logic        irq_err
);

    // R12: channel counts limited to 1..MAX_CH
    if (TX_CH < 1 || TX_CH > MAX_CH) begin : g_bad_tx
        $error("TX_CH out of range");
    end
    if (RX_CH < 1 || RX_CH > MAX_CH) begin : g_bad_rx
        $error("RX_CH out of range");
    end

    logic [DATA_W-1:0]                 core_rd, txp_rd, rxp_rd, bsz_rd;
    logic [IRQ_GROUPS-1:0][DATA_W-1:0] stat;
    logic [IRQ_GROUPS-1:0]             ien;
    logic [IRQ_GROUPS-1:0]             irq;
    logic [DATA_W-1:0]                 rd_data_d, rd_data_q;

    dma_csr_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_num_i     (reg_num),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .err_set_i     (err_set),
        .tx_eob_set_i  (tx_eob_set),
        .rx_eob_set_i  (rx_eob_set),
        .tx_derr_set_i (tx_derr_set),
        .rx_derr_set_i (rx_derr_set),
        .rdata_o       (core_rd),
        .stat_o        (stat),
        .ien_o         (ien)
    );

    dma_win_bank #(.N(TX_CH), .BASE(WIN_TXPTR), .KEEP(PTR_KEEP)) u_txptr (
        .clk (clk), .rst_n (rst_n), .reg_num_i (reg_num),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rdata_o (txp_rd)
    );

    dma_win_bank #(.N(RX_CH), .BASE(WIN_RXPTR), .KEEP(PTR_KEEP)) u_rxptr (
        .clk (clk), .rst_n (rst_n), .reg_num_i (reg_num),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rdata_o (rxp_rd)
    );

    dma_win_bank #(.N(RX_CH), .BASE(WIN_RXBSZ), .KEEP(BSZ_KEEP)) u_rxbsz (
        .clk (clk), .rst_n (rst_n), .reg_num_i (reg_num),
        .wr_en_i (wr_en), .wr_data_i (wr_data), .rdata_o (bsz_rd)
    );

    dma_irq_merge #(.GROUPS(IRQ_GROUPS)) u_irq (
        .stat_i (stat),
        .en_i   (ien),
        .irq_o  (irq)
    );

    // sources decode disjoint numbers, so unselected ones return zero
    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) rd_data_d = core_rd | txp_rd | rxp_rd | bsz_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign rd_data     = rd_data_q;
    assign irq_tx_eob  = irq[IG_TX_EOB];
    assign irq_rx_eob  = irq[IG_RX_EOB];
    assign irq_tx_derr = irq[IG_TX_DERR];
    assign irq_rx_derr = irq[IG_RX_DERR];
    assign irq_err     = irq[IG_ERR];

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    a_r2_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !rd_en |=> $stable(rd_data));

    a_r8_disable_silences: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && wr_en && (reg_num == CSR_IRQEN) && (wr_data[4:0] == 5'd0)
        |=> !(irq_tx_eob || irq_rx_eob || irq_tx_derr || irq_rx_derr || irq_err));

endmodule

// File: tb/dma_chan_csr_test.sv
module dma_chan_csr_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_num = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] err_set = '0, tx_eob_set = '0, rx_eob_set = '0;
    logic [31:0] tx_derr_set = '0, rx_derr_set = '0;
    logic        irq_tx_eob, irq_rx_eob, irq_tx_derr, irq_rx_derr, irq_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dma_chan_csr #(.TX_CH(4), .RX_CH(2)) uut (
        .clk, .rst_n, .reg_num, .wr_en, .wr_data, .rd_en, .rd_data,
        .err_set, .tx_eob_set, .rx_eob_set, .tx_derr_set, .rx_derr_set,
        .irq_tx_eob, .irq_rx_eob, .irq_tx_derr, .irq_rx_derr, .irq_err
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] num, input logic [31:0] val);
        @(negedge clk);
        reg_num = num; wr_data = val; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] num, output logic [31:0] val);
        @(negedge clk);
        reg_num = num; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [9:0] num, input logic [31:0] exp);
        logic [31:0] v;
        do_read(num, v);
        check(req, v, exp);
    endtask

    function automatic logic [31:0] irqs();
        return {27'd0, irq_err, irq_rx_derr, irq_tx_derr, irq_rx_eob, irq_tx_eob};
    endfunction

    task automatic t_reset;
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 irq lines", irqs(), 32'h0);
        expect_reg("R1 cfg", 10'h180, 32'h0007_C000);
        expect_reg("R1 err", 10'h181, 32'h0);
        expect_reg("R1 txact set", 10'h184, 32'h0);
        expect_reg("R1 rxeob", 10'h192, 32'h0);
        expect_reg("R1 txptr0", 10'h1A0, 32'h0);
    endtask

    task automatic t_cfg_mask;
        do_write(10'h180, 32'h7FFF_FFFF);
        expect_reg("R3 cfg mask", 10'h180, 32'h00FF_C087);
    endtask

    task automatic t_masks;
        do_write(10'h182, 32'hFFFF_FFFF);
        expect_reg("R5 irq enable", 10'h182, 32'h0000_001F);
        do_write(10'h184, 32'hFFFF_FFFF);
        expect_reg("R5 txact set", 10'h184, 32'hF000_0000);
        do_write(10'h185, 32'hFFFF_FFFF);
        expect_reg("R5 txact reset", 10'h185, 32'hF000_0000);
        do_write(10'h190, 32'hFFFF_FFFF);
        expect_reg("R5 rxact set", 10'h190, 32'hC000_0000);
        do_write(10'h191, 32'hFFFF_FFFF);
        expect_reg("R5 rxact reset", 10'h191, 32'hC000_0000);
    endtask

    task automatic t_status;
        @(negedge clk); err_set = 32'h5;
        @(negedge clk); err_set = '0;
        check("R8 irq_err on", {31'd0, irq_err}, 32'h1);
        expect_reg("R7 err set", 10'h181, 32'h5);
        do_write(10'h181, 32'h1);
        expect_reg("R6 err w1c", 10'h181, 32'h4);
        @(negedge clk);
        reg_num = 10'h181; wr_data = 32'h5; wr_en = 1'b1; err_set = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; err_set = '0;
        expect_reg("R7 set wins", 10'h181, 32'h1);
        @(negedge clk); tx_eob_set = 32'hF000_0000;
        @(negedge clk); tx_eob_set = '0;
        do_write(10'h186, 32'h3000_0000);
        expect_reg("R6 txeob w1c", 10'h186, 32'hC000_0000);
        check("R8 eob lines", irqs(), 32'h11);
        do_write(10'h182, 32'h0000_000F);
        check("R8 err gated", irqs(), 32'h01);
        @(negedge clk); rx_derr_set = 32'h2;
        @(negedge clk); rx_derr_set = '0;
        check("R8 rx derr line", irqs(), 32'h09);
        do_write(10'h193, 32'h0);
        expect_reg("R6 zero write keeps", 10'h193, 32'h2);
    endtask

    task automatic t_windows;
        for (int i = 0; i < 4; i++) do_write(10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
        for (int i = 0; i < 4; i++) expect_reg("R9 txptr", 10'h1A0 + 10'(i), 32'hA000_0000 + 32'(i));
        do_write(10'h1A4, 32'hDEAD_BEEF);
        expect_reg("R11 past tx window", 10'h1A4, 32'h0);
        expect_reg("R11 no alias", 10'h1A0, 32'hA000_0000);
        do_write(10'h1C0, 32'h1111_1111);
        do_write(10'h1C1, 32'h2222_2222);
        expect_reg("R9 rxptr0", 10'h1C0, 32'h1111_1111);
        expect_reg("R9 rxptr1", 10'h1C1, 32'h2222_2222);
        expect_reg("R11 past rx window", 10'h1C2, 32'h0);
        do_write(10'h1E0, 32'h1234_5678);
        do_write(10'h1E1, 32'hFFFF_FF03);
        expect_reg("R10 bufsize0", 10'h1E0, 32'h78);
        expect_reg("R10 bufsize1", 10'h1E1, 32'h03);
        do_write(10'h1E2, 32'hFFFF_FFFF);
        expect_reg("R11 past bsz window", 10'h1E2, 32'h0);
        do_write(10'h183, 32'hFFFF_FFFF);
        expect_reg("R11 hole reads zero", 10'h183, 32'h0);
        expect_reg("R11 hole write ignored", 10'h182, 32'h0F);
    endtask

    task automatic t_readpath;
        logic [31:0] v;
        do_read(10'h182, v);
        check("R2 read", v, 32'h0F);
        do_write(10'h182, 32'h03);
        check("R2 hold without strobe", rd_data, 32'h0F);
        @(negedge clk);
        reg_num = 10'h182; wr_data = 32'h1C; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R2 old value on shared cycle", rd_data, 32'h03);
        expect_reg("R2 new value", 10'h182, 32'h1C);
    endtask

    task automatic t_soft;
        do_write(10'h180, 32'h8000_0081);
        check("R4 irq lines cleared", irqs(), 32'h0);
        expect_reg("R4 cfg stored", 10'h180, 32'h0000_0081);
        expect_reg("R4 ien cleared", 10'h182, 32'h0);
        expect_reg("R4 err cleared", 10'h181, 32'h0);
        expect_reg("R4 txeob cleared", 10'h186, 32'h0);
        expect_reg("R4 rxderr cleared", 10'h193, 32'h0);
        expect_reg("R4 txact set cleared", 10'h184, 32'h0);
        expect_reg("R4 rxact set cleared", 10'h190, 32'h0);
        expect_reg("R4 txact reset kept", 10'h185, 32'hF000_0000);
        expect_reg("R4 rxact reset kept", 10'h191, 32'hC000_0000);
        expect_reg("R4 txptr kept", 10'h1A1, 32'hA000_0001);
        expect_reg("R4 bufsize kept", 10'h1E0, 32'h78);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg_mask();
        t_masks();
        t_status();
        t_windows();
        t_readpath();
        t_soft();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule